// File: doc/BRIEF.md
# Pixel Format Expander with Colour Map

This block sits in a scan-out path. It takes raw framebuffer pixel words from a valid/ready stream and turns each one into a 32-bit RGBA word with 8 bits per channel: alpha in [31:24], red in [23:16], green in [15:8] and blue in [7:0]. A single global attribute entry sets how the words are read. That entry holds a 4-bit format code, a 4-bit colour-map bank and a gamma-bypass bit.

Direct-colour formats are unpacked bit by bit. A channel narrower than 8 bits is widened by repeating its high bits into the low bits. The two 8-bit formats can instead use their byte as an index into a 1024-entry colour map of 32-bit ARGB words. A flag in the format code turns that lookup off.

Each accepted pixel takes one cycle, whichever path it uses, so output order always matches input order. A shared write port loads the colour-map entries and the attribute entry. The gamma-bypass bit only travels on to a later stage, through its own output.

Top module: `pixfmt_expander`

## Requirements
- R1: After reset, out_valid is 0, in_ready is 1 and gamma_bypass is 0. The attribute entry reads as format 0 (24-bit) with bank 0.
- R2: A write with wr_sel=1 loads the attribute entry: format from wr_data[3:0], bank from wr_data[7:4], gamma bypass from wr_data[8]. The address is ignored. gamma_bypass shows the new bit in the cycle after the write.
- R3: Format 0 (24-bit) gives red=pix[23:16], green=pix[15:8], blue=pix[7:0] and alpha=0xFF. pix[31:24] is ignored.
- R4: Format 3 (32-bit) gives alpha=pix[31:24] and takes red, green and blue as in R3.
- R5: Format 1 (5:6:5) reads blue from [4:0], green from [10:5] and red from [15:11]. A 5-bit value v widens to v*8+v/4, a 6-bit value v to v*4+v/16, and alpha is 0xFF.
- R6: Format 2 (1:5:5:5) reads blue from [4:0], green from [9:5] and red from [14:10], each widened as in R5. Alpha is 0xFF when pix[15]=1 and 0x00 when pix[15]=0.
- R7: Format 10 (8-bit indexed) outputs the colour-map entry at pix[7:0] + 64*bank, unchanged.
- R8: The colour-map index is (pix[7:0] + bank*64) mod 1024 for every bank value 0 to 15.
- R9: Bit 2 of the format code (value 4) turns off the colour map. Codes 4 to 7 act as codes 0 to 3. Code 13 unpacks 3:3:2: red=[7:5] and green=[4:2], each widened as v*36+v/2; blue=[1:0], widened as v*85; alpha is 0xFF. Code 14 outputs grey, with red=green=blue=pix[7:0] and alpha 0xFF.
- R10: Format 9 (3:3:2) with bit 2 clear uses the colour map exactly as in R7.
- R11: A colour-map write (wr_sel=0) to an address of 1024 or above has no effect on any entry.
- R12: in_ready equals !out_valid || out_ready. A pixel accepted on an edge is presented in the next cycle. Output order matches input order. While out_valid=1 and out_ready=0, out_rgba is held.
- R13: Any code whose value with bit 2 cleared is 8 or 11 outputs 0xFF000000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe for the config port |
| wr_sel | input | 1 | 0: colour-map entry, 1: attribute entry |
| wr_addr | input | WR_ADDR_W (11) | Colour-map write address |
| wr_data | input | 32 | Write data |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Input pixel accepted when high with in_valid |
| in_pix | input | 32 | Raw pixel word |
| out_valid | output | 1 | Output RGBA valid |
| out_ready | input | 1 | Downstream ready |
| out_rgba | output | 32 | A[31:24] R[23:16] G[15:8] B[7:0] |
| gamma_bypass | output | 1 | Gamma-bypass bit from the attribute entry |

## Verification
The bench loads every colour-map entry with a value computed arithmetically, so each index returns a distinct word. It then sweeps every 8-bit value through indexed, 3:3:2 and grey mode, and sweeps 16-bit values at a fine stride through 5:6:5 and 1:5:5:5. These sweeps tell the channel positions and the high-bit widening apart from shifted or zero-filled variants. Indexed sweeps across several banks, including bank 15 where the index wraps, separate a correct offset from a missing or unshifted one. Out-of-range map writes, unlisted codes, and a stalled output with a second pixel waiting check rejection, default black and ordering under back-pressure.

// File: rtl/pxe_pkg.sv
package pxe_pkg;

   localparam int unsigned PIX_W     = 32;
   localparam int unsigned NOPAL_BIT = 2;

   localparam logic [3:0] FMT_RGB24    = 4'd0;
   localparam logic [3:0] FMT_RGB565   = 4'd1;
   localparam logic [3:0] FMT_ARGB1555 = 4'd2;
   localparam logic [3:0] FMT_ARGB32   = 4'd3;
   localparam logic [3:0] FMT_RGB332   = 4'd9;
   localparam logic [3:0] FMT_INDEX8   = 4'd10;

   typedef struct packed {
      logic [7:0] a;
      logic [7:0] r;
      logic [7:0] g;
      logic [7:0] b;
   } pxe_rgba_t;

   typedef struct packed {
      logic       gamma_off;
      logic [3:0] bank;
      logic [3:0] fmt;
   } pxe_attr_t;

   // Widen a w-bit value held in the low bits of v by repeating its bits from the top.
   function automatic logic [7:0] widen(input logic [7:0] v, input int unsigned w);
      logic [7:0] res;
      for (int k = 0; k < 8; k++) begin
         res[7-k] = v[w - 1 - (k % w)];
      end
      return res;
   endfunction

endpackage

// File: rtl/pxe_attr_reg.sv
module pxe_attr_reg
   import pxe_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_en,
   input  logic        wr_sel,
   input  logic [31:0] wr_data,
   output pxe_attr_t   attr
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         attr <= '0;
      end else if (wr_en && wr_sel) begin
         attr.fmt       <= wr_data[3:0];
         attr.bank      <= wr_data[7:4];
         attr.gamma_off <= wr_data[8];
      end
   end

endmodule

// File: rtl/pxe_cmap.sv
module pxe_cmap #(
   parameter int unsigned DEPTH     = 1024,
   parameter int unsigned WR_ADDR_W = 11,
   parameter int unsigned DATA_W    = 32
) (
   input  logic                         clk,
   input  logic                         we,
   input  logic [WR_ADDR_W-1:0]         waddr,
   input  logic [DATA_W-1:0]            wdata,
   input  logic                         re,
   input  logic [$clog2(DEPTH)-1:0]     raddr,
   output logic [DATA_W-1:0]            rdata
);

   localparam int unsigned IDX_W = $clog2(DEPTH);

   if ((1 << IDX_W) != DEPTH) begin : g_bad_depth
      $error("pxe_cmap: DEPTH must be a power of two");
   end
   if (WR_ADDR_W <= IDX_W) begin : g_bad_addr
      $error("pxe_cmap: WR_ADDR_W must exceed the index width");
   end

   logic [DATA_W-1:0] mem [DEPTH];
   logic              in_range;

   assign in_range = (waddr < WR_ADDR_W'(DEPTH));

   always_ff @(posedge clk) begin
      if (we && in_range) begin
         mem[waddr[IDX_W-1:0]] <= wdata;
      end
      if (re) begin
         rdata <= mem[raddr];
      end
   end

endmodule

// File: rtl/pxe_direct.sv
module pxe_direct
   import pxe_pkg::*;
(
   input  logic [3:0]       base_fmt,
   input  logic [PIX_W-1:0] pix,
   output pxe_rgba_t        rgba
);

   always_comb begin
      rgba = '{a: 8'hFF, r: 8'h00, g: 8'h00, b: 8'h00};
      unique case (base_fmt)
         FMT_RGB24: begin
            rgba.r = pix[23:16];
            rgba.g = pix[15:8];
            rgba.b = pix[7:0];
         end
         FMT_ARGB32: begin
            rgba.a = pix[31:24];
            rgba.r = pix[23:16];
            rgba.g = pix[15:8];
            rgba.b = pix[7:0];
         end
         FMT_RGB565: begin
            rgba.r = widen(8'(pix[15:11]), 5);
            rgba.g = widen(8'(pix[10:5]), 6);
            rgba.b = widen(8'(pix[4:0]), 5);
         end
         FMT_ARGB1555: begin
            rgba.a = {8{pix[15]}};
            rgba.r = widen(8'(pix[14:10]), 5);
            rgba.g = widen(8'(pix[9:5]), 5);
            rgba.b = widen(8'(pix[4:0]), 5);
         end
         FMT_RGB332: begin
            rgba.r = widen(8'(pix[7:5]), 3);
            rgba.g = widen(8'(pix[4:2]), 3);
            rgba.b = widen(8'(pix[1:0]), 2);
         end
         FMT_INDEX8: begin
            rgba.r = pix[7:0];
            rgba.g = pix[7:0];
            rgba.b = pix[7:0];
         end
         default: ;
      endcase
   end

endmodule

// File: rtl/pixfmt_expander.sv
module pixfmt_expander
   import pxe_pkg::*;
#(
   parameter int unsigned CMAP_DEPTH = 1024,
   parameter int unsigned WR_ADDR_W  = 11,
   parameter int unsigned BANK_SHIFT = 6
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic                 wr_sel,
   input  logic [WR_ADDR_W-1:0] wr_addr,
   input  logic [31:0]          wr_data,
   input  logic                 in_valid,
   output logic                 in_ready,
   input  logic [31:0]          in_pix,
   output logic                 out_valid,
   input  logic                 out_ready,
   output logic [31:0]          out_rgba,
   output logic                 gamma_bypass
);

   localparam int unsigned IDX_W  = $clog2(CMAP_DEPTH);
   localparam int unsigned BANK_W = 4;

   if (IDX_W < 8) begin : g_bad_idx
      $error("pixfmt_expander: colour map must hold at least 256 entries");
   end
   if (BANK_SHIFT + BANK_W > IDX_W) begin : g_bad_bank
      $error("pixfmt_expander: bank field does not fit the index");
   end

   pxe_attr_t           attr;
   logic [3:0]          base_fmt;
   logic                use_pal;
   logic                accept;
   logic [IDX_W-1:0]    pal_idx;
   pxe_rgba_t           direct_rgba;
   pxe_rgba_t           direct_q;
   logic                use_pal_q;
   logic                vld_q;
   logic [31:0]         pal_word;

   pxe_attr_reg u_attr (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_sel  (wr_sel),
      .wr_data (wr_data),
      .attr    (attr)
   );

   assign base_fmt = attr.fmt & ~(4'(1) << NOPAL_BIT);
   assign use_pal  = !attr.fmt[NOPAL_BIT] &&
                     ((base_fmt == FMT_INDEX8) || (base_fmt == FMT_RGB332));
   assign pal_idx  = IDX_W'(in_pix[7:0]) + (IDX_W'(attr.bank) << BANK_SHIFT);

   assign in_ready = !vld_q || out_ready;
   assign accept   = in_valid && in_ready;

   pxe_cmap #(
      .DEPTH     (CMAP_DEPTH),
      .WR_ADDR_W (WR_ADDR_W),
      .DATA_W    (32)
   ) u_cmap (
      .clk   (clk),
      .we    (wr_en && !wr_sel),
      .waddr (wr_addr),
      .wdata (wr_data),
      .re    (accept),
      .raddr (pal_idx),
      .rdata (pal_word)
   );

   pxe_direct u_direct (
      .base_fmt (base_fmt),
      .pix      (in_pix),
      .rgba     (direct_rgba)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         vld_q     <= 1'b0;
         use_pal_q <= 1'b0;
         direct_q  <= '0;
      end else if (accept) begin
         vld_q     <= 1'b1;
         use_pal_q <= use_pal;
         direct_q  <= direct_rgba;
      end else if (out_ready) begin
         vld_q     <= 1'b0;
      end
   end

   assign out_valid    = vld_q;
   assign out_rgba     = use_pal_q ? pal_word : direct_q;
   assign gamma_bypass = attr.gamma_off;

endmodule

// File: rtl/pxe_chk.sv
module pxe_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        wr_en,
   input logic        wr_sel,
   input logic [31:0] wr_data,
   input logic        in_valid,
   input logic        in_ready,
   input logic        out_valid,
   input logic        out_ready,
   input logic [31:0] out_rgba,
   input logic        gamma_bypass
);

   // R12
   stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |=> (out_valid && $stable(out_rgba)));

   // R12
   accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> out_valid);

   // R12
   drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!in_valid && out_valid && out_ready) |=> !out_valid);

   // R12
   backpressure_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && !out_ready) |-> !in_ready);

   // R2
   gamma_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_sel) |=> (gamma_bypass == $past(wr_data[8])));

endmodule

bind pixfmt_expander pxe_chk u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .wr_en        (wr_en),
   .wr_sel       (wr_sel),
   .wr_data      (wr_data),
   .in_valid     (in_valid),
   .in_ready     (in_ready),
   .out_valid    (out_valid),
   .out_ready    (out_ready),
   .out_rgba     (out_rgba),
   .gamma_bypass (gamma_bypass)
);

// File: tb/pixfmt_expander_test.sv
`timescale 1ns/1ps
module pixfmt_expander_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic        wr_sel = 1'b0;
   logic [10:0] wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic        in_valid = 1'b0;
   logic        in_ready;
   logic [31:0] in_pix = '0;
   logic        out_valid;
   logic        out_ready = 1'b1;
   logic [31:0] out_rgba;
   logic        gamma_bypass;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   logic        pend = 1'b0;
   logic [31:0] pend_exp;
   string       pend_req;

   always #2.5 clk = ~clk;

   pixfmt_expander uut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_addr(wr_addr),
      .wr_data(wr_data), .in_valid(in_valid), .in_ready(in_ready), .in_pix(in_pix),
      .out_valid(out_valid), .out_ready(out_ready), .out_rgba(out_rgba),
      .gamma_bypass(gamma_bypass)
   );

   function automatic logic [7:0] e5(input int v); return 8'(v * 8 + v / 4); endfunction
   function automatic logic [7:0] e6(input int v); return 8'(v * 4 + v / 16); endfunction
   function automatic logic [7:0] e3(input int v); return 8'(v * 36 + v / 2); endfunction
   function automatic logic [7:0] e2(input int v); return 8'(v * 85); endfunction
   function automatic logic [31:0] palv(input int i);
      return 32'(i * 32'h0103_0507) ^ 32'hA5C3_0F96;
   endfunction

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic check_pending();
      if (pend) begin
         check({pend_req, " valid"}, 32'(out_valid), 32'd1);
         check(pend_req, out_rgba, pend_exp);
      end
   endtask

   task automatic push(input logic [31:0] p, input logic [31:0] e, input string req);
      @(negedge clk);
      check_pending();
      in_valid = 1'b1;
      in_pix   = p;
      pend     = 1'b1;
      pend_exp = e;
      pend_req = req;
   endtask

   task automatic idle();
      @(negedge clk);
      check_pending();
      in_valid = 1'b0;
      pend     = 1'b0;
      wr_en    = 1'b0;
   endtask

   task automatic wr(input logic sel, input int addr, input logic [31:0] d);
      @(negedge clk);
      check_pending();
      in_valid = 1'b0;
      pend     = 1'b0;
      wr_en    = 1'b1;
      wr_sel   = sel;
      wr_addr  = 11'(addr);
      wr_data  = d;
   endtask

   task automatic set_attr(input int fmt, input int bank, input bit gam);
      wr(1'b1, 0, {23'd0, gam, 4'(bank), 4'(fmt)});
      idle();
   endtask

   initial begin
      #(5.0 * 190000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog actual hung expected finished");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      logic [31:0] p;
      int          r, g, b;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1 out_valid", 32'(out_valid), 32'd0);
      check("R1 in_ready", 32'(in_ready), 32'd1);
      check("R1 gamma_bypass", 32'(gamma_bypass), 32'd0);
      // R1 default format is 24-bit
      push(32'hAB12_3456, 32'hFF12_3456, "R1 default fmt");
      idle();

      // Fill the colour map
      for (int i = 0; i < 1024; i++) wr(1'b0, i, palv(i));
      idle();

      // R2 attribute write with gamma bit
      set_attr(0, 0, 1'b1);
      check("R2 gamma set", 32'(gamma_bypass), 32'd1);

      // R3 24-bit, R9 code 4 behaves as 0
      for (int i = 0; i < 256; i++) begin
         p = {8'(i), 8'(i * 3), 8'(i ^ 8'h5A), ~8'(i)};
         push(p, {8'hFF, p[23:0]}, "R3");
      end
      set_attr(4, 0, 1'b0);
      check("R2 gamma clear", 32'(gamma_bypass), 32'd0);
      for (int i = 0; i < 64; i++) begin
         p = {~8'(i), 8'(i * 5), 8'(i), 8'(i + 7)};
         push(p, {8'hFF, p[23:0]}, "R9 code4");
      end

      // R4 32-bit, R9 code 7
      set_attr(3, 0, 1'b0);
      for (int i = 0; i < 256; i++) begin
         p = {8'(i * 7), 8'(i), ~8'(i), 8'(i ^ 8'h33)};
         push(p, p, "R4");
      end
      set_attr(7, 0, 1'b0);
      for (int i = 0; i < 32; i++) begin
         p = {8'(i * 11), 8'(i), 8'(i + 1), 8'(i + 2)};
         push(p, p, "R9 code7");
      end

      // R5 5:6:5 sweep
      set_attr(1, 0, 1'b0);
      for (int v = 0; v < 65536; v += 3) begin
         r = (v >> 11) & 31; g = (v >> 5) & 63; b = v & 31;
         push({~16'(v), 16'(v)}, {8'hFF, e5(r), e6(g), e5(b)}, "R5");
      end
      set_attr(5, 0, 1'b0);
      for (int v = 0; v < 65536; v += 97) begin
         r = (v >> 11) & 31; g = (v >> 5) & 63; b = v & 31;
         push({16'h0, 16'(v)}, {8'hFF, e5(r), e6(g), e5(b)}, "R9 code5");
      end

      // R6 1:5:5:5 sweep
      set_attr(2, 0, 1'b0);
      for (int v = 0; v < 65536; v += 3) begin
         r = (v >> 10) & 31; g = (v >> 5) & 31; b = v & 31;
         push({16'(v * 5), 16'(v)}, {((v >> 15) & 1) ? 8'hFF : 8'h00, e5(r), e5(g), e5(b)}, "R6");
      end

      // R7 indexed, bank 0
      set_attr(10, 0, 1'b0);
      for (int i = 0; i < 256; i++) push({24'hABCDEF, 8'(i)}, palv(i), "R7");
      // R8 banks including the wrap at 15
      for (int bk = 1; bk < 16; bk += 7) begin
         set_attr(10, bk, 1'b0);
         for (int i = 0; i < 256; i++) push(32'(i), palv((i + bk * 64) % 1024), "R8");
      end
      set_attr(10, 5, 1'b0);
      for (int i = 0; i < 256; i += 5) push(32'(i), palv((i + 320) % 1024), "R8 bank5");

      // R10 3:3:2 through the map
      set_attr(9, 3, 1'b0);
      for (int i = 0; i < 256; i++) push(32'(i), palv(i + 192), "R10");

      // R9 3:3:2 bypass and grey
      set_attr(13, 3, 1'b0);
      for (int i = 0; i < 256; i++)
         push({24'h123456, 8'(i)}, {8'hFF, e3((i >> 5) & 7), e3((i >> 2) & 7), e2(i & 3)}, "R9 332");
      set_attr(14, 9, 1'b0);
      for (int i = 0; i < 256; i++) push({24'hFFFFFF, 8'(i)}, {8'hFF, 8'(i), 8'(i), 8'(i)}, "R9 grey");

      // R13 unlisted codes
      set_attr(8, 0, 1'b0);
      push(32'hFFFF_FFFF, 32'hFF00_0000, "R13 code8");
      set_attr(11, 0, 1'b0);
      push(32'h1234_5678, 32'hFF00_0000, "R13 code11");
      set_attr(12, 0, 1'b0);
      push(32'h0000_00FF, 32'hFF00_0000, "R13 code12");
      set_attr(15, 0, 1'b0);
      push(32'h8765_4321, 32'hFF00_0000, "R13 code15");
      idle();

      // R11 out-of-range map writes ignored
      wr(1'b0, 1024 + 5, 32'hDEAD_BEEF);
      wr(1'b0, 2047, 32'hCAFE_F00D);
      wr(1'b0, 1024, 32'h0BAD_0BAD);
      idle();
      set_attr(10, 0, 1'b0);
      push(32'd5, palv(5), "R11 idx5");
      push(32'd255, palv(255), "R11 idx255");
      push(32'd0, palv(0), "R11 idx0");
      set_attr(10, 15, 1'b0);
      push(32'd63, palv(1023), "R11 idx1023");
      idle();

      // R12 back-pressure and order
      set_attr(0, 0, 1'b0);
      @(negedge clk);
      out_ready = 1'b0;
      in_valid  = 1'b1;
      in_pix    = 32'h0011_2233;
      @(negedge clk);
      check("R12 first valid", 32'(out_valid), 32'd1);
      check("R12 first data", out_rgba, 32'hFF11_2233);
      check("R12 in_ready low", 32'(in_ready), 32'd0);
      in_pix = 32'h0044_5566;
      @(negedge clk);
      check("R12 held data", out_rgba, 32'hFF11_2233);
      check("R12 still blocked", 32'(in_ready), 32'd0);
      out_ready = 1'b1;
      @(negedge clk);
      check("R12 second valid", 32'(out_valid), 32'd1);
      check("R12 second data", out_rgba, 32'hFF44_5566);
      in_valid = 1'b0;
      @(negedge clk);
      check("R12 drained", 32'(out_valid), 32'd0);

      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule